// File: doc/BRIEF.md
# SDRAM Bank State Tracker

The tracker watches a decoded command stream on a mobile DDR SDRAM channel and keeps, for each of four banks, whether the bank is idle, has a row open, or is closing (precharging). It also records the open row address for each bank. It applies the rules for row activation, column access, explicit precharge of one bank or of every bank, auto-precharge requested with a column command, and early termination of a read burst. A command that breaks these rules is flagged for one cycle.

The block is meant to sit beside a memory controller's command issue stage, or in a protocol monitor. The precharge time and the burst length are parameters counted in clock cycles. Each bank has its own down-counter for the precharge phase. A single shared tracker follows the burst that is currently transferring, because only one data burst can be on the bus at any time. All outputs are registered, so a command sampled at one rising edge shows its effect after that edge.

Command codes on `cmd_op`: 0 no operation, 1 activate, 2 read, 3 write, 4 precharge, 5 burst terminate. Codes 6 and 7 are unused. Bank state codes on `bank_st`, two bits per bank, with bank n in bits [2n+1:2n]: 0 idle, 1 open, 2 closing.

Top module: `sdr_bank_monitor`

## Requirements
- R1: After a synchronous active-high reset, every bank reads idle (code 0), every open-row field reads zero, and `cmd_err` is low.
- R2: An activate (op 1) to an idle bank makes that bank read open (code 1) after the sampling edge, with its row field holding `cmd_row`.
- R3: An activate to a bank that is open or closing raises `cmd_err` for the cycle after the sampling edge and changes no bank.
- R4: A precharge (op 4) with `cmd_a10` low moves only the bank selected by `cmd_bank` from open to closing (code 2), and leaves the other banks unchanged.
- R5: A precharge with `cmd_a10` high moves every open bank to closing, whatever value `cmd_bank` holds.
- R6: A precharge aimed at a bank that is idle or already closing has no effect on that bank, and does not restart its closing count.
- R7: A bank that starts closing at edge k reads idle after edge k+TRP, and its row field then reads zero. A closing bank never goes straight back to open.
- R8: A read (op 2) or write (op 3) to a bank that is not open raises `cmd_err` and changes nothing.
- R9: A read or write with `cmd_a10` high, sampled at edge k, keeps the bank open through edge k+BL-1. The bank then starts closing at edge k+BL with no further command.
- R10: While an auto-precharge burst is still transferring, any read or write to any bank raises `cmd_err` and is dropped. Once that burst has ended, reads and writes to other open banks are accepted.
- R11: A burst terminate (op 5) is accepted while a read without auto-precharge is transferring, and that bank's row stays open. Burst terminate raises `cmd_err` when no such read is in flight: no burst at all, a write burst, an auto-precharge read, a read already terminated, or a read whose bank has been precharged.
- R12: Codes 6 and 7, op 0, and any command with `cmd_vld` low change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_vld | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | BANK_W (2) | Bank address |
| cmd_a10 | input | 1 | All-bank select on precharge; auto-precharge request on read or write |
| cmd_row | input | ROW_W (13) | Row address for activate |
| bank_st | output | 2*NB (8) | Per-bank state, 2 bits per bank |
| bank_row | output | ROW_W*NB (52) | Per-bank open row, ROW_W bits per bank |
| cmd_err | output | 1 | Previous command broke a rule |

## Verification
A wrong bank state or a wrong closing count shows at the ports within one cycle of the faulty edge. It appears on that bank's `bank_st` field, or on a row field that fails to return to zero. A lost or stale record of the in-flight burst has no visible effect until a later command depends on it. It then shows as a missing or spurious `cmd_err` on a column command or burst terminate, or as a bank that fails to close BL cycles after an auto-precharge access. For that reason the stimulus must follow bursts with further column and terminate commands, not only with state reads.

// File: rtl/bank_mon_pkg.sv
package bank_mon_pkg;
    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_st_e;

    localparam logic [2:0] OP_NOP = 3'd0;
    localparam logic [2:0] OP_ACT = 3'd1;
    localparam logic [2:0] OP_RD  = 3'd2;
    localparam logic [2:0] OP_WR  = 3'd3;
    localparam logic [2:0] OP_PRE = 3'd4;
    localparam logic [2:0] OP_BST = 3'd5;
endpackage

// File: rtl/bank_slot.sv
module bank_slot
    import bank_mon_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int TRP   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output bank_st_e         st_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int CW = $clog2(TRP + 1);

    typedef struct packed {
        bank_st_e         st;
        logic [ROW_W-1:0] row;
        logic [CW-1:0]    cnt;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        case (slot_q.st)
            BK_IDLE: begin
                if (open_i) begin
                    slot_d.st  = BK_OPEN;
                    slot_d.row = row_i;
                end
            end
            BK_OPEN: begin
                if (close_i) begin
                    slot_d.st  = BK_CLOSING;
                    slot_d.cnt = CW'(TRP);
                end
            end
            BK_CLOSING: begin
                if (slot_q.cnt <= CW'(1)) begin
                    slot_d.st  = BK_IDLE;
                    slot_d.row = '0;
                    slot_d.cnt = '0;
                end else begin
                    slot_d.cnt = slot_q.cnt - CW'(1);
                end
            end
            default: slot_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign st_o  = slot_q.st;
    assign row_o = slot_q.row;
endmodule

// File: rtl/burst_track.sv
module burst_track #(
    parameter int BANK_W = 2,
    parameter int BL     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              start_rd_i,
    input  logic              start_ap_i,
    input  logic [BANK_W-1:0] start_bank_i,
    input  logic              kill_i,
    output logic              live_o,
    output logic              is_rd_o,
    output logic              ap_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              fin_o
);
    localparam int CW = $clog2(BL + 1);

    typedef struct packed {
        logic              live;
        logic              rd;
        logic              ap;
        logic [BANK_W-1:0] bank;
        logic [CW-1:0]     cnt;
    } burst_t;

    burst_t br_d, br_q;

    always_comb begin
        br_d = br_q;
        if (start_i) begin
            br_d.live = 1'b1;
            br_d.rd   = start_rd_i;
            br_d.ap   = start_ap_i;
            br_d.bank = start_bank_i;
            br_d.cnt  = CW'(BL);
        end else if (kill_i) begin
            br_d.live = 1'b0;
        end else if (br_q.live) begin
            if (br_q.cnt <= CW'(1)) br_d.live = 1'b0;
            else                    br_d.cnt  = br_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) br_q <= '0;
        else     br_q <= br_d;
    end

    assign live_o  = br_q.live;
    assign is_rd_o = br_q.rd;
    assign ap_o    = br_q.ap;
    assign bank_o  = br_q.bank;
    assign fin_o   = br_q.live && (br_q.cnt <= CW'(1));
endmodule

// File: rtl/sdr_bank_monitor.sv
module sdr_bank_monitor
    import bank_mon_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int TRP    = 3,
    parameter int BL     = 4,
    localparam int NB    = 1 << BANK_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_vld,
    input  logic [2:0]          cmd_op,
    input  logic [BANK_W-1:0]   cmd_bank,
    input  logic                cmd_a10,
    input  logic [ROW_W-1:0]    cmd_row,
    output logic [2*NB-1:0]     bank_st,
    output logic [ROW_W*NB-1:0] bank_row,
    output logic                cmd_err
);
    bank_st_e          st_w  [NB];
    logic [ROW_W-1:0]  row_w [NB];
    logic [NB-1:0]     open_v, close_v, pre_tgt;

    logic              bt_live, bt_rd, bt_ap, bt_fin;
    logic [BANK_W-1:0] bt_bank;
    logic              rw_ok, bst_ok, kill;

    typedef struct packed {
        logic err;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        logic is_act, is_rw, is_pre, is_bst;
        bank_st_e sel;
        is_act = cmd_vld && (cmd_op == OP_ACT);
        is_rw  = cmd_vld && ((cmd_op == OP_RD) || (cmd_op == OP_WR));
        is_pre = cmd_vld && (cmd_op == OP_PRE);
        is_bst = cmd_vld && (cmd_op == OP_BST);
        sel    = st_w[cmd_bank];

        for (int b = 0; b < NB; b++) begin
            pre_tgt[b] = is_pre && (cmd_a10 || (cmd_bank == BANK_W'(b)));
            open_v[b]  = is_act && (cmd_bank == BANK_W'(b)) && (st_w[b] == BK_IDLE);
            close_v[b] = pre_tgt[b] || (bt_fin && bt_ap && (bt_bank == BANK_W'(b)));
        end

        rw_ok  = is_rw && (sel == BK_OPEN) && !(bt_live && bt_ap);
        bst_ok = is_bst && bt_live && bt_rd && !bt_ap;
        kill   = bst_ok || pre_tgt[bt_bank];

        top_d.err = (is_act && (sel != BK_IDLE))
                  || (is_rw && !rw_ok)
                  || (is_bst && !bst_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    burst_track #(.BANK_W(BANK_W), .BL(BL)) u_burst (
        .clk          (clk),
        .rst          (rst),
        .start_i      (rw_ok),
        .start_rd_i   (cmd_op == OP_RD),
        .start_ap_i   (cmd_a10),
        .start_bank_i (cmd_bank),
        .kill_i       (kill),
        .live_o       (bt_live),
        .is_rd_o      (bt_rd),
        .ap_o         (bt_ap),
        .bank_o       (bt_bank),
        .fin_o        (bt_fin)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        bank_slot #(.ROW_W(ROW_W), .TRP(TRP)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .open_i  (open_v[g]),
            .close_i (close_v[g]),
            .row_i   (cmd_row),
            .st_o    (st_w[g]),
            .row_o   (row_w[g])
        );
        assign bank_st[2*g +: 2]          = st_w[g];
        assign bank_row[ROW_W*g +: ROW_W] = row_w[g];
    end

    assign cmd_err = top_q.err;
endmodule

// File: rtl/bank_mon_chk.sv
module bank_mon_chk #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int TRP    = 3,
    parameter int BL     = 4,
    localparam int NB    = 1 << BANK_W
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_vld,
    input logic [2:0]          cmd_op,
    input logic [BANK_W-1:0]   cmd_bank,
    input logic                cmd_a10,
    input logic [ROW_W-1:0]    cmd_row,
    input logic [2*NB-1:0]     bank_st,
    input logic [ROW_W*NB-1:0] bank_row,
    input logic                cmd_err
);
    logic [1:0]    sel_st;
    logic [NB-1:0] open_vec;

    assign sel_st = bank_st[2*int'(cmd_bank) +: 2];

    for (genvar g = 0; g < NB; g++) begin : g_open
        assign open_vec[g] = (bank_st[2*g +: 2] == 2'd1);
    end

    AST_ACT_BUSY_FLAG: assert property (@(posedge clk) disable iff (rst)
        cmd_vld && cmd_op == 3'd1 && sel_st != 2'd0 |=> cmd_err); // R3

    AST_RW_CLOSED_FLAG: assert property (@(posedge clk) disable iff (rst)
        cmd_vld && (cmd_op == 3'd2 || cmd_op == 3'd3) && sel_st != 2'd1 |=> cmd_err); // R8

    AST_ALL_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        cmd_vld && cmd_op == 3'd4 && cmd_a10 |=> open_vec == '0); // R5

    for (genvar g = 0; g < NB; g++) begin : g_bank_chk
        AST_IDLE_PRE_NOOP: assert property (@(posedge clk) disable iff (rst)
            cmd_vld && cmd_op == 3'd4 && bank_st[2*g +: 2] == 2'd0
            |=> bank_st[2*g +: 2] == 2'd0); // R6

        AST_CLOSE_NO_REOPEN: assert property (@(posedge clk) disable iff (rst)
            bank_st[2*g +: 2] == 2'd2 |=> bank_st[2*g +: 2] != 2'd1); // R7

        AST_IDLE_ROW_ZERO: assert property (@(posedge clk) disable iff (rst)
            bank_st[2*g +: 2] == 2'd0 |-> bank_row[ROW_W*g +: ROW_W] == '0); // R7

        AST_STATE_CODE: assert property (@(posedge clk) disable iff (rst)
            bank_st[2*g +: 2] != 2'd3); // R2
    end
endmodule

bind sdr_bank_monitor bank_mon_chk #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .TRP    (TRP),
    .BL     (BL)
) u_chk (.*);

// File: tb/sdr_bank_monitor_tb.sv
`timescale 1ns/1ps
module sdr_bank_monitor_tb;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 13;
    localparam int TRP    = 3;
    localparam int BL     = 4;
    localparam int NB     = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cmd_vld = 1'b0;
    logic [2:0]          cmd_op = 3'd0;
    logic [BANK_W-1:0]   cmd_bank = '0;
    logic                cmd_a10 = 1'b0;
    logic [ROW_W-1:0]    cmd_row = '0;
    logic [2*NB-1:0]     bank_st;
    logic [ROW_W*NB-1:0] bank_row;
    logic                cmd_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  reported = 1'b0;

    // reference state
    int m_st [NB];
    int m_row[NB];
    int m_cnt[NB];
    bit bv, brd, bap, m_err;
    int bb, bc;

    always #5 clk = ~clk;

    sdr_bank_monitor #(.BANK_W(BANK_W), .ROW_W(ROW_W), .TRP(TRP), .BL(BL)) u_dut (
        .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_a10(cmd_a10), .cmd_row(cmd_row), .bank_st(bank_st), .bank_row(bank_row),
        .cmd_err(cmd_err)
    );

    function automatic void model_reset();
        for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_row[b] = 0; m_cnt[b] = 0; end
        bv = 0; brd = 0; bap = 0; bb = 0; bc = 0; m_err = 0;
    endfunction

    function automatic void model(bit v, int op, int bk, bit a10, int row);
        int s0[NB];
        bit bv0 = bv, brd0 = brd, bap0 = bap;
        int bb0 = bb;
        for (int b = 0; b < NB; b++) s0[b] = m_st[b];
        m_err = 0;
        for (int b = 0; b < NB; b++)
            if (m_st[b] == 2) begin
                if (m_cnt[b] == 1) begin m_st[b] = 0; m_row[b] = 0; end
                else m_cnt[b]--;
            end
        if (bv0) begin
            if (bc == 1) begin
                bv = 0;
                if (bap0) begin m_st[bb0] = 2; m_cnt[bb0] = TRP; end
            end else bc--;
        end
        if (v) case (op)
            1: if (s0[bk] != 0) m_err = 1; else begin m_st[bk] = 1; m_row[bk] = row; end
            2, 3: if (s0[bk] != 1 || (bv0 && bap0)) m_err = 1;
                  else begin bv = 1; bc = BL; brd = (op == 2); bap = a10; bb = bk; end
            4: for (int b = 0; b < NB; b++)
                   if ((a10 || b == bk) && s0[b] == 1) begin
                       m_st[b] = 2; m_cnt[b] = TRP;
                       if (bv0 && bb0 == b) bv = 0;
                   end
            5: if (bv0 && brd0 && !bap0) bv = 0; else m_err = 1;
            default: ;
        endcase
    endfunction

    task automatic check(string tag);
        for (int b = 0; b < NB; b++) begin
            n_chk++;
            if (int'(bank_st[2*b +: 2]) != m_st[b]) begin
                n_bad++;
                $display("FAIL %s bank%0d state act=%0d exp=%0d", tag, b, bank_st[2*b +: 2], m_st[b]);
            end
            n_chk++;
            if (int'(bank_row[ROW_W*b +: ROW_W]) != m_row[b]) begin
                n_bad++;
                $display("FAIL %s bank%0d row act=%0h exp=%0h", tag, b, bank_row[ROW_W*b +: ROW_W], m_row[b]);
            end
        end
        n_chk++;
        if (cmd_err != m_err) begin
            n_bad++;
            $display("FAIL %s err act=%0b exp=%0b", tag, cmd_err, m_err);
        end
    endtask

    // called at a falling edge: drive, predict the next rising edge, check at the next falling edge
    task automatic step(bit v, int op, int bk, bit a10, int row, string tag);
        cmd_vld = v; cmd_op = 3'(op); cmd_bank = 2'(bk); cmd_a10 = a10; cmd_row = 13'(row);
        model(v, op, bk, a10, row);
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset");

        step(1, 1, 0, 0, 'h123, "R2 act b0");
        step(1, 1, 0, 0, 'h55,  "R3 act on open bank");
        step(1, 1, 1, 0, 'h0aa, "R2 act b1");
        step(1, 4, 0, 0, 0,     "R4 pre b0 only");
        step(1, 1, 0, 0, 'h7,   "R3 act on closing bank");
        step(1, 4, 0, 0, 0,     "R6 pre closing bank no restart");
        idle(1, "R7 closing count");
        step(1, 4, 0, 1, 0,     "R6 pre-all while b0 closing");
        idle(TRP + 1, "R7 back to idle");
        step(1, 2, 0, 0, 0,     "R8 read idle bank");
        step(1, 3, 3, 0, 0,     "R8 write idle bank");

        step(1, 1, 2, 0, 'h1f0, "R2 act b2");
        step(1, 1, 1, 0, 'h0bb, "R2 act b1");
        step(1, 2, 2, 1, 0,     "R9 read auto-pre b2");
        step(1, 3, 1, 0, 0,     "R10 write during auto-pre burst");
        step(1, 5, 0, 0, 0,     "R11 terminate auto-pre read");
        idle(BL - 2, "R9 burst running");
        step(1, 2, 1, 0, 0,     "R10 read after auto-pre burst");
        step(1, 5, 3, 0, 0,     "R11 terminate plain read");
        step(1, 5, 3, 0, 0,     "R11 terminate twice");
        step(1, 3, 1, 0, 0,     "R11 write burst");
        step(1, 5, 1, 0, 0,     "R11 terminate write");
        step(1, 2, 1, 0, 0,     "R11 read again");
        idle(BL, "R11 read ends");
        step(1, 5, 1, 0, 0,     "R11 terminate after end");
        step(1, 2, 1, 0, 0,     "R11 read before pre");
        step(1, 4, 1, 0, 0,     "R4 pre ends read");
        step(1, 5, 1, 0, 0,     "R11 terminate after pre");
        idle(TRP + 2, "R7 settle");

        step(1, 1, 0, 0, 'h3,   "R2 act b0");
        step(1, 1, 3, 0, 'h1ff, "R2 act b3");
        step(1, 6, 0, 0, 0,     "R12 unused op 6");
        step(1, 7, 3, 1, 0,     "R12 unused op 7");
        step(0, 4, 0, 1, 0,     "R12 pre without valid");
        step(0, 1, 1, 0, 'h9,   "R12 act without valid");
        step(1, 4, 2, 1, 0,     "R5 pre-all bank bits ignored");
        idle(TRP + 1, "R7 all idle");

        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 16);
            int bk = int'($urandom % 4);
            int row = int'($urandom % 8192);
            bit a = ($urandom % 4) == 0;
            case (r)
                0, 1, 2, 3: step(1, 1, bk, a, row, "R2 rand act");
                4, 5, 6:    step(1, 2, bk, a, row, "R9 rand read");
                7, 8:       step(1, 3, bk, a, row, "R8 rand write");
                9, 10:      step(1, 4, bk, ($urandom % 3) == 0, row, "R4 rand pre");
                11, 12:     step(1, 5, bk, a, row, "R11 rand terminate");
                13:         step(1, 0, bk, a, row, "R12 rand nop");
                14:         step(1, 6 + int'($urandom % 2), bk, a, row, "R12 rand unused");
                default:    step(0, int'($urandom % 8), bk, a, row, "R12 rand invalid");
            endcase
        end
        finish_run();
    end
endmodule